// File: doc/BRIEF.md
# Toeplitz Shift Message Digest

This block computes an authentication digest over a message that arrives one bit at a time. A start pulse loads a shifting hash register from a key and clears a running digest. Each accepted message bit shifts the hash register right by one place, and that bit enters the freed most significant position. When the bit is a one, the register value after the shift is XORed into the running digest. A zero bit leaves the digest untouched.

The bit flagged as last closes the message. One cycle later a single-cycle done pulse appears, and the finished digest is presented on the output at the same time. The digest stays on the output until the next message completes, so the transmitter can append it to the data it sends. The receiver recomputes the digest and compares it to detect any change to the data.

Top module: `toeplitz_digest`

## Requirements
- R1: While reset is asserted and after it is released, `done_o` is 0 and `digest_o` is all zeros.
- R2: A cycle with `start_i` high loads the hash register from `key_i` and clears the running digest. Results from earlier messages have no effect on the new digest.
- R3: Each accepted bit shifts the hash register right by one position, with the accepted bit entering the most significant bit. The first message bit sent is the first one shifted in.
- R4: When an accepted bit is 1, the hash register value after that bit's shift is XORed into the running digest. When the bit is 0, the running digest is unchanged.
- R5: `done_o` is high for exactly one cycle, in the cycle after the one in which the bit with `bit_last_i` high is accepted. `digest_o` shows the final digest from that cycle and holds it until the next `done_o`.
- R6: A `start_i` cycle with `bit_last_i` high marks an empty message. `done_o` follows in the next cycle with an all-zero digest.
- R7: `bit_vld_i`, `bit_i` and `bit_last_i` are ignored while no message is open. They cause no `done_o` and leave `digest_o` unchanged.
- R8: A `start_i` pulse during an open message abandons that message and begins a new one from the new key.
- R9: No message bit is accepted in a `start_i` cycle, even with `bit_vld_i` high. The first bit is taken in a later cycle.
- R10: Cycles inside a message with `bit_vld_i` low neither shift the hash register nor change the digest.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a new message and loads the key |
| key_i | input | WIDTH | Initial value of the hash register, taken with `start_i` |
| bit_vld_i | input | 1 | Qualifies `bit_i` as a message bit |
| bit_i | input | 1 | Serial message bit |
| bit_last_i | input | 1 | Marks the accepted bit as the final one. With `start_i`, marks an empty message |
| digest_o | output | WIDTH | Final digest, updated together with `done_o` |
| done_o | output | 1 | One-cycle pulse when the digest is ready |

## Verification
A wrong hash register or digest state stays hidden until the message ends. It then shows up only in `digest_o`, in the cycle of the `done_o` pulse. A single wrong shift or a missed XOR usually changes many digest bits, because every later one-bit folds in the corrupted register. A fault in the controller shows up sooner: as a missing, early, repeated or spurious `done_o`, or as `digest_o` changing outside a done cycle. Messages of different lengths, with and without idle gaps, and with varied keys are compared against an independent model. This lets faults in the register and faults in the control path each show at the ports.

// File: rtl/tsd_pkg.sv
package tsd_pkg;

   // Message framing state of the controller
   typedef enum logic [0:0] {
      TSD_IDLE = 1'b0,
      TSD_OPEN = 1'b1
   } tsd_state_e;

   // Smallest digest width the block supports
   localparam int unsigned TSD_MIN_WIDTH = 2;

endpackage

// File: rtl/tsd_shift_reg.sv
module tsd_shift_reg #(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [WIDTH-1:0] key_i,
   input  logic             shift_i,
   input  logic             bit_i,
   output logic [WIDTH-1:0] q_o,
   output logic [WIDTH-1:0] next_o
);
   localparam int unsigned TOP = WIDTH - 1;

   logic [WIDTH-1:0] q_r;

   if (WIDTH < tsd_pkg::TSD_MIN_WIDTH) begin : g_width_chk
      $error("tsd_shift_reg: WIDTH below minimum");
   end

   // Post-shift value, one slice per bit position
   for (genvar i = 0; i < WIDTH; i++) begin : g_slice
      if (i == TOP) begin : g_msb
         assign next_o[i] = bit_i;
      end else begin : g_body
         assign next_o[i] = q_r[i+1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_r <= '0;
      end else if (load_i) begin
         q_r <= key_i;
      end else if (shift_i) begin
         q_r <= next_o;
      end
   end

   assign q_o = q_r;

   AST_MSB_FROM_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_i && !load_i) |=> (q_r[TOP] == $past(bit_i)))
      else $error("msb not refilled from message bit"); // R3

   AST_HOLD_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      (!shift_i && !load_i) |=> $stable(q_r))
      else $error("hash register moved without shift"); // R10

endmodule

// File: rtl/tsd_accum.sv
module tsd_accum #(
   parameter int unsigned WIDTH     = 32,
   parameter bit          AND_GATED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             add_i,
   input  logic             bit_i,
   input  logic [WIDTH-1:0] val_i,
   output logic [WIDTH-1:0] acc_o,
   output logic [WIDTH-1:0] acc_next_o
);
   logic [WIDTH-1:0] acc_r;
   logic [WIDTH-1:0] term;
   logic             take;

   if (WIDTH < tsd_pkg::TSD_MIN_WIDTH) begin : g_width_chk
      $error("tsd_accum: WIDTH below minimum");
   end

   assign take = add_i & bit_i;

   // Two ways to gate the folded term: bitwise AND or a word multiplexer
   if (AND_GATED) begin : g_and
      assign term = val_i & {WIDTH{take}};
   end else begin : g_mux
      always_comb begin
         if (take) term = val_i;
         else      term = '0;
      end
   end

   assign acc_next_o = acc_r ^ term;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_r <= '0;
      end else if (clear_i) begin
         acc_r <= '0;
      end else begin
         acc_r <= acc_next_o;
      end
   end

   assign acc_o = acc_r;

   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (acc_r == '0))
      else $error("accumulator not cleared"); // R2

   AST_ZERO_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear_i && !(add_i && bit_i)) |=> $stable(acc_r))
      else $error("accumulator changed on zero bit"); // R4

endmodule

// File: rtl/tsd_ctrl.sv
module tsd_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic vld_i,
   input  logic last_i,
   output logic open_o,
   output logic load_o,
   output logic shift_o,
   output logic finish_o,
   output logic done_o
);
   import tsd_pkg::*;

   tsd_state_e state_r;
   tsd_state_e state_n;
   logic       done_r;
   logic       bit_take;

   // No bit is taken in a start cycle
   assign bit_take = (state_r == TSD_OPEN) && vld_i && !start_i;
   assign load_o   = start_i;
   assign shift_o  = bit_take;
   assign finish_o = (start_i && last_i) || (bit_take && last_i);

   always_comb begin
      state_n = state_r;
      if (start_i) begin
         state_n = last_i ? TSD_IDLE : TSD_OPEN;
      end else if (bit_take && last_i) begin
         state_n = TSD_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_r <= TSD_IDLE;
         done_r  <= 1'b0;
      end else begin
         state_r <= state_n;
         done_r  <= finish_o;
      end
   end

   assign open_o = (state_r == TSD_OPEN);
   assign done_o = done_r;

   AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (open_o && vld_i && last_i && !start_i) |=> (done_o && !open_o))
      else $error("no done after last bit"); // R5

   AST_IDLE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (!open_o && !start_i) |=> (!done_o && !open_o))
      else $error("idle input produced activity"); // R7

   AST_EMPTY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && last_i) |=> (done_o && !open_o))
      else $error("empty message not closed"); // R6

   AST_RESTART_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !last_i) |=> (open_o && !done_o))
      else $error("start did not open message"); // R8

endmodule

// File: rtl/toeplitz_digest.sv
module toeplitz_digest #(
   parameter int unsigned WIDTH     = 32,
   parameter bit          AND_GATED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [WIDTH-1:0] key_i,
   input  logic             bit_vld_i,
   input  logic             bit_i,
   input  logic             bit_last_i,
   output logic [WIDTH-1:0] digest_o,
   output logic             done_o
);
   logic             open_w;
   logic             load_w;
   logic             shift_w;
   logic             finish_w;
   logic [WIDTH-1:0] hreg_q;
   logic [WIDTH-1:0] hreg_next;
   logic [WIDTH-1:0] acc_q;
   logic [WIDTH-1:0] acc_next;
   logic [WIDTH-1:0] digest_r;

   if (WIDTH < tsd_pkg::TSD_MIN_WIDTH) begin : g_width_chk
      $error("toeplitz_digest: WIDTH below minimum");
   end

   tsd_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .vld_i    (bit_vld_i),
      .last_i   (bit_last_i),
      .open_o   (open_w),
      .load_o   (load_w),
      .shift_o  (shift_w),
      .finish_o (finish_w),
      .done_o   (done_o)
   );

   tsd_shift_reg #(.WIDTH(WIDTH)) u_hreg (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load_w),
      .key_i   (key_i),
      .shift_i (shift_w),
      .bit_i   (bit_i),
      .q_o     (hreg_q),
      .next_o  (hreg_next)
   );

   tsd_accum #(.WIDTH(WIDTH), .AND_GATED(AND_GATED)) u_acc (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear_i    (load_w),
      .add_i      (shift_w),
      .bit_i      (bit_i),
      .val_i      (hreg_next),
      .acc_o      (acc_q),
      .acc_next_o (acc_next)
   );

   // Output holding register, refreshed only when a message closes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         digest_r <= '0;
      end else if (finish_w) begin
         digest_r <= load_w ? '0 : acc_next;
      end
   end

   assign digest_o = digest_r;

   AST_DIGEST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      done_o || $stable(digest_o))
      else $error("digest moved outside done"); // R5

   AST_NO_BIT_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (hreg_q == $past(key_i)))
      else $error("key not loaded cleanly"); // R9

   AST_OPEN_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      (open_w && !bit_vld_i && !start_i) |=> ($stable(acc_q) && open_w))
      else $error("gap cycle altered state"); // R10

endmodule

// File: tb/toeplitz_digest_test.sv
module toeplitz_digest_test;
   localparam int W = 32;
   localparam int NV = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic [W-1:0] key_i = '0;
   logic         bit_vld_i = 1'b0;
   logic         bit_i = 1'b0;
   logic         bit_last_i = 1'b0;
   logic [W-1:0] digest_o;
   logic         done_o;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk; // 50 MHz

   toeplitz_digest #(.WIDTH(W)) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .key_i(key_i),
      .bit_vld_i(bit_vld_i), .bit_i(bit_i), .bit_last_i(bit_last_i),
      .digest_o(digest_o), .done_o(done_o)
   );

   localparam logic [W-1:0] KEYS [NV] = '{
      32'hA5A5_1234, 32'h0000_0000, 32'hFFFF_FFFF, 32'h1357_9BDF,
      32'hDEAD_BEEF, 32'h8000_0001, 32'h0F0F_F0F0, 32'h7654_3210 };
   localparam logic [63:0] MSGS [NV] = '{
      64'h0000_0000_0000_00B5, 64'h0123_4567_89AB_CDEF, 64'h0000_0000_0000_0000,
      64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0001_DEAD_0000, 64'h8000_0000_0000_0001,
      64'h5555_AAAA_3333_CCCC, 64'h0000_0000_0003_FFFF };
   localparam int LENS [NV] = '{8, 64, 17, 40, 33, 64, 50, 20};

   // Independent model of the shift-and-fold rule
   function automatic logic [W-1:0] model(input logic [W-1:0] key,
                                          input logic [63:0] msg, input int len);
      logic [W-1:0] r = key;
      logic [W-1:0] a = '0;
      for (int i = 0; i < len; i++) begin
         r = {msg[i], r[W-1:1]};
         if (msg[i]) a = a ^ r;
      end
      return a;
   endfunction

   task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp,
                        input string req);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Sends one message; bits are driven at negedges, results sampled at negedges
   task automatic send(input logic [W-1:0] key, input logic [63:0] msg,
                       input int len, input bit gaps, input bit vld_on_start,
                       input logic [W-1:0] exp, input string req);
      @(negedge clk);
      start_i = 1'b1; key_i = key; bit_vld_i = vld_on_start; bit_i = 1'b1;
      bit_last_i = (len == 0);
      @(negedge clk);
      start_i = 1'b0; bit_last_i = 1'b0; bit_vld_i = 1'b0;
      for (int i = 0; i < len; i++) begin
         if (gaps && (i % 3 == 1)) begin
            bit_vld_i = 1'b0; bit_i = 1'b1; bit_last_i = 1'b1;
            @(negedge clk);
            check({31'd0, done_o}, 32'd0, {req, " R10 gap no done"});
         end
         bit_vld_i = 1'b1; bit_i = msg[i]; bit_last_i = (i == len - 1);
         @(negedge clk);
      end
      bit_vld_i = 1'b0; bit_last_i = 1'b0; bit_i = 1'b0;
      check({31'd0, done_o}, 32'd1, {req, " R5 done"});
      check(digest_o, exp, {req, " R4 digest"});
      @(negedge clk);
      check({31'd0, done_o}, 32'd0, {req, " R5 one cycle"});
      check(digest_o, exp, {req, " R5 hold"});
   endtask

   initial begin
      #3_000_000;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check({31'd0, done_o}, 32'd0, "R1 done in reset");
      check(digest_o, '0, "R1 digest in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check({31'd0, done_o}, 32'd0, "R1 done after reset");

      // Table walk against the model, odd entries with gaps
      for (int v = 0; v < NV; v++) begin
         send(KEYS[v], MSGS[v], LENS[v], (v % 2) == 1, 1'b0,
              model(KEYS[v], MSGS[v], LENS[v]), "R2 R3 table");
      end

      // Hand cases: single 1 bit, then 1,1 from zero key
      send(32'h0, 64'h1, 1, 1'b0, 1'b0, 32'h8000_0000, "R3 single one");
      send(32'h0, 64'h3, 2, 1'b0, 1'b0, 32'h4000_0000, "R4 two ones");
      send(32'hFFFF_FFFF, 64'h0, 1, 1'b0, 1'b0, 32'h0, "R4 zero bit");

      // Empty message
      send(32'h1234_5678, 64'h0, 0, 1'b0, 1'b0, 32'h0, "R6 empty");

      // Bit offered in the start cycle is not taken
      send(32'hCAFE_0001, 64'h0000_0000_0000_0A6C, 12, 1'b0, 1'b1,
           model(32'hCAFE_0001, 64'h0A6C, 12), "R9 start bit");

      // Idle input ignored
      send(32'h0, 64'h1, 1, 1'b0, 1'b0, 32'h8000_0000, "R7 setup");
      for (int k = 0; k < 4; k++) begin
         bit_vld_i = 1'b1; bit_i = 1'b1; bit_last_i = 1'b1;
         @(negedge clk);
         check({31'd0, done_o}, 32'd0, "R7 idle no done");
         check(digest_o, 32'h8000_0000, "R7 idle digest held");
      end
      bit_vld_i = 1'b0; bit_last_i = 1'b0;

      // Restart in the middle of a message
      @(negedge clk);
      start_i = 1'b1; key_i = 32'hFFFF_0000;
      @(negedge clk);
      start_i = 1'b0;
      for (int i = 0; i < 5; i++) begin
         bit_vld_i = 1'b1; bit_i = 1'b1;
         @(negedge clk);
      end
      bit_vld_i = 1'b0;
      send(32'h0BAD_F00D, 64'h0000_0000_00C3_5A96, 24, 1'b0, 1'b0,
           model(32'h0BAD_F00D, 64'hC3_5A96, 24), "R8 restart");

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule